// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the register file that a processor bus sees in front of an interrupt redirection engine. Software does not address registers directly. It first writes a register number into an 8-bit selector at window offset 0x00, then reads or writes a 32-bit data port at offset 0x10. The selector leads to an identifier register, a read-only version word, an arbitration word that is always zero, and a table of redirection entries, one per interrupt pin. Each entry is 64 bits wide and is reached as a low and a high 32-bit half at two neighbouring selector values.

The whole table goes to the servicing engine as one flat vector. A one-cycle `entry_changed` pulse after every accepted entry write tells the engine to re-evaluate its pins. The engine returns two live status flags per pin, remote-IRR and delivery status. These flags show up in the entry read data, and software cannot write them. The bus side is a valid-only request port with no ready signal. The block takes every request in the cycle it is presented, so there is no back-pressure. A read answers with `rd_valid` and `rd_data` exactly one cycle later.

Top module: `irq_regwin`

## Requirements
- R1: After reset the selector and identifier are zero, every entry holds 0x0000_0000_0001_0000 (only the mask bit, bit 16, set), and `entry_changed` is low.
- R2: Offset 0x00 is the selector. It is written from `req_wdata[7:0]` for any access size, and a read returns it in bits 7:0 with the other bits zero.
- R3: An access to offset 0x10 whose `req_size` is not 4 has no effect when it is a write, reads back zero, and gives no `entry_changed` pulse.
- R4: Selector 0 is the identifier. A write stores only `req_wdata[27:24]`, and a read returns the identifier in bits 27:24 with every other bit zero.
- R5: Selector 1 reads 0x11 in bits 7:0 and NPINS-1 in bits 23:16, with zeros elsewhere. Writes to it are ignored.
- R6: Selector 2 always reads zero and ignores writes.
- R7: Selector 0x10+2n reaches bits 31:0 of entry n, and 0x11+2n reaches bits 63:32. A write changes only the half it addresses.
- R8: Selectors 3 to 0x0F and 0x10+2*NPINS and above read zero, and writes to them change no entry.
- R9: Every accepted write to an entry half gives `entry_changed` high for one cycle, in the cycle after the write. Other writes give no pulse.
- R10: Entry bits 14 and 12 are never stored from writes. On a low-half read they return `remote_irr_i[n]` and `deliv_stat_i[n]` as sampled in the request cycle.
- R11: `rd_valid` goes high exactly in the cycle after each read request and is low at all other times. `rd_data` is valid while `rd_valid` is high.
- R12: `table_o[64n +: 64]` shows the stored entry n, with bits 14 and 12 zero, starting in the cycle after the write.
- R13: Only address bits 7:0 are decoded. Any other low-byte offset reads zero and its writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle (always accepted) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address inside the 4 KB region |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Registered read data |
| remote_irr_i | input | NPINS | Live remote-IRR flag per pin from the engine |
| deliv_stat_i | input | NPINS | Live delivery-status flag per pin from the engine |
| entry_changed | output | 1 | One-cycle pulse after an entry write |
| table_o | output | NPINS*64 | All stored entries, entry n at bits 64n+63:64n |

## Verification
The bench drives reads of every register class: selector, identifier, version, arbitration, both halves of the first, a middle and the last entry, out-of-range selectors, and stray offsets. Each read result is compared against a queue of expected words. Writes with all ones show which bits each register keeps. Half-word writes to one entry show that the other half survives. Narrow-size writes and reads show that the size gate is separate from the selector path. Toggling the engine status inputs between reads shows that bits 14 and 12 come from live status and not from storage. The strobe is sampled after each write, which tells entry writes apart from identifier, version and out-of-range writes.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ENTRY_W = 64;
  localparam int unsigned SEL_W   = 8;

  localparam logic [7:0] OFS_SELECT = 8'h00;
  localparam logic [7:0] OFS_DATA   = 8'h10;
  localparam logic [2:0] FULL_SIZE  = 3'd4;

  localparam logic [SEL_W-1:0] SEL_IDENT    = 8'h00;
  localparam logic [SEL_W-1:0] SEL_VERSION  = 8'h01;
  localparam logic [SEL_W-1:0] SEL_ARBIT    = 8'h02;
  localparam logic [SEL_W-1:0] SEL_TBL_BASE = 8'h10;

  localparam logic [7:0] VERSION_CODE = 8'h11;

  localparam int unsigned MASK_POS  = 16;
  localparam int unsigned RIRR_POS  = 14;
  localparam int unsigned DSTAT_POS = 12;

  localparam logic [ENTRY_W-1:0] ENTRY_RESET = ENTRY_W'(1) << MASK_POS;
  localparam logic [WORD_W-1:0]  LOW_RO_MASK =
    (WORD_W'(1) << RIRR_POS) | (WORD_W'(1) << DSTAT_POS);

  typedef enum logic [2:0] {
    TGT_IDENT,
    TGT_VERSION,
    TGT_ARBIT,
    TGT_ENTRY,
    TGT_NONE
  } tgt_e;
endpackage

// File: rtl/irq_regwin_decode.sv
module irq_regwin_decode
  import irq_regwin_pkg::*;
#(
  parameter int unsigned NPINS = 24,
  parameter int unsigned NUM_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic [SEL_W-1:0] sel_i,
  output tgt_e             tgt_o,
  output logic [NUM_W-1:0] num_o,
  output logic             hi_o
);
  logic [SEL_W-1:0] rel;
  logic [SEL_W-2:0] pair;

  always_comb begin
    rel   = sel_i - SEL_TBL_BASE;
    pair  = rel[SEL_W-1:1];
    hi_o  = sel_i[0];
    num_o = NUM_W'(pair);
    tgt_o = TGT_NONE;
    if (sel_i == SEL_IDENT) begin
      tgt_o = TGT_IDENT;
    end else if (sel_i == SEL_VERSION) begin
      tgt_o = TGT_VERSION;
    end else if (sel_i == SEL_ARBIT) begin
      tgt_o = TGT_ARBIT;
    end else if (sel_i >= SEL_TBL_BASE && 32'(pair) < NPINS) begin
      tgt_o = TGT_ENTRY;
    end
  end
endmodule

// File: rtl/irq_regwin_bank.sv
module irq_regwin_bank
  import irq_regwin_pkg::*;
#(
  parameter int unsigned NPINS = 24,
  parameter int unsigned NUM_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic                     wr_hi_i,
  input  logic [NUM_W-1:0]         wr_num_i,
  input  logic [WORD_W-1:0]        wr_data_i,
  output logic [NPINS*ENTRY_W-1:0] table_o,
  output logic                     changed_o
);
  for (genvar n = 0; n < NPINS; n++) begin : g_entry
    logic [ENTRY_W-1:0] ent_q;
    logic               hit;

    assign hit = wr_en_i && (wr_num_i == NUM_W'(n));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q <= ENTRY_RESET;
      end else if (hit) begin
        if (wr_hi_i) ent_q[ENTRY_W-1:WORD_W] <= wr_data_i;
        else         ent_q[WORD_W-1:0]       <= wr_data_i & ~LOW_RO_MASK;
      end
    end

    assign table_o[n*ENTRY_W +: ENTRY_W] = ent_q;

    // R10: status bit positions never hold written data
    a_r10_status_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
      !table_o[n*ENTRY_W + RIRR_POS] && !table_o[n*ENTRY_W + DSTAT_POS]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) changed_o <= 1'b0;
    else        changed_o <= wr_en_i;
  end

  // R9: any change of the exported table comes with the strobe
  a_r9_change_strobed: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(table_o) |-> changed_o);
endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
  import irq_regwin_pkg::*;
#(
  parameter int unsigned NPINS  = 24,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_we,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [2:0]               req_size,
  input  logic [WORD_W-1:0]        req_wdata,
  output logic                     rd_valid,
  output logic [WORD_W-1:0]        rd_data,
  input  logic [NPINS-1:0]         remote_irr_i,
  input  logic [NPINS-1:0]         deliv_stat_i,
  output logic                     entry_changed,
  output logic [NPINS*ENTRY_W-1:0] table_o
);
  localparam int unsigned NUM_W = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [7:0]  MAX_ENTRY = 8'(NPINS - 1);

  logic [SEL_W-1:0] sel_q;
  logic [3:0]       ident_q;
  tgt_e             tgt;
  logic [NUM_W-1:0] num;
  logic             hi;
  logic             at_sel, at_data, full;
  logic             wr_entry;
  logic [ENTRY_W-1:0] ent_live;
  logic [WORD_W-1:0]  win_val, rd_next;

  assign at_sel   = req_addr[7:0] == OFS_SELECT;
  assign at_data  = req_addr[7:0] == OFS_DATA;
  assign full     = req_size == FULL_SIZE;
  assign wr_entry = req_valid && req_we && at_data && full && (tgt == TGT_ENTRY);

  irq_regwin_decode #(.NPINS(NPINS), .NUM_W(NUM_W)) u_dec (
    .sel_i(sel_q), .tgt_o(tgt), .num_o(num), .hi_o(hi)
  );

  irq_regwin_bank #(.NPINS(NPINS), .NUM_W(NUM_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_entry), .wr_hi_i(hi),
    .wr_num_i(num), .wr_data_i(req_wdata),
    .table_o(table_o), .changed_o(entry_changed)
  );

  always_comb begin
    ent_live = '0;
    if (tgt == TGT_ENTRY) begin
      ent_live            = table_o[num*ENTRY_W +: ENTRY_W];
      ent_live[RIRR_POS]  = remote_irr_i[num];
      ent_live[DSTAT_POS] = deliv_stat_i[num];
    end
    unique case (tgt)
      TGT_IDENT:   win_val = {4'b0, ident_q, 24'b0};
      TGT_VERSION: win_val = {8'b0, MAX_ENTRY, 8'b0, VERSION_CODE};
      TGT_ENTRY:   win_val = hi ? ent_live[ENTRY_W-1:WORD_W] : ent_live[WORD_W-1:0];
      default:     win_val = '0;
    endcase
    rd_next = '0;
    if (at_sel)               rd_next = {{(WORD_W-SEL_W){1'b0}}, sel_q};
    else if (at_data && full) rd_next = win_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      ident_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_we;
      if (req_valid && !req_we) rd_data <= rd_next;
      if (req_valid && req_we && at_sel) sel_q <= req_wdata[SEL_W-1:0];
      if (req_valid && req_we && at_data && full && tgt == TGT_IDENT)
        ident_q <= req_wdata[27:24];
    end
  end

  // R11: one response per read, one cycle later
  a_r11_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rd_valid);
  a_r11_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rd_valid);
  // R3: narrow data-port writes leave the table alone
  a_r3_narrow_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && at_data && !full) |=> ($stable(table_o) && !entry_changed));
  // R13: writes at stray offsets leave the table alone
  a_r13_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && !at_data) |=> $stable(table_o));
endmodule

// File: tb/irq_regwin_test.sv
module irq_regwin_test;
  localparam int NP = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n, req_valid, req_we;
  logic [11:0]      req_addr;
  logic [2:0]       req_size;
  logic [31:0]      req_wdata, rd_data;
  logic             rd_valid, entry_changed;
  logic [NP-1:0]    remote_irr_i, deliv_stat_i;
  logic [NP*64-1:0] table_o;

  irq_regwin #(.NPINS(NP), .ADDR_W(12)) uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        strobe_seen;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read words
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R11 stray rd_valid", 1, 0);
      else check(tag_q.pop_front(), {32'b0, rd_data}, {32'b0, exp_q.pop_front()});
    end
  end

  task automatic wr(logic [11:0] a, logic [2:0] sz, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_we = 0;
    strobe_seen = entry_changed;
  endtask

  task automatic rd(logic [11:0] a, logic [2:0] sz, logic [31:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1; req_we = 0; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic sel(logic [7:0] s);
    wr(12'h000, 3'd4, {24'b0, s});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_we = 0; req_addr = 0; req_size = 0;
    req_wdata = 0; remote_irr_i = 0; deliv_stat_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 strobe after reset", {63'b0, entry_changed}, 0);
    begin
      int bad = 0;
      for (int n = 0; n < NP; n++)
        if (table_o[n*64 +: 64] !== 64'h0000_0000_0001_0000) bad++;
      check("R1 reset table", bad, 0);
    end
    rd(12'h000, 3'd4, 32'h0, "R1 R2 selector reset");
    rd(12'h010, 3'd4, 32'h0, "R1 R4 ident reset");
    sel(8'h10);
    rd(12'h010, 3'd4, 32'h0001_0000, "R1 R7 entry0 low reset");
    sel(8'h11);
    rd(12'h010, 3'd4, 32'h0, "R1 R7 entry0 high reset");

    // R2 selector byte write, any size
    wr(12'h000, 3'd1, 32'hFFFF_FFA5);
    rd(12'h000, 3'd1, 32'h0000_00A5, "R2 selector write");

    // R4 identifier
    sel(8'h00);
    wr(12'h010, 3'd4, 32'hFFFF_FFFF);
    check("R9 no strobe on ident", {63'b0, strobe_seen}, 0);
    rd(12'h010, 3'd4, 32'h0F00_0000, "R4 ident bits");

    // R5 version
    sel(8'h01);
    rd(12'h010, 3'd4, 32'h0017_0011, "R5 version");
    wr(12'h010, 3'd4, 32'h1234_5678);
    rd(12'h010, 3'd4, 32'h0017_0011, "R5 version after write");

    // R6 arbitration
    sel(8'h02);
    wr(12'h010, 3'd4, 32'hFFFF_FFFF);
    rd(12'h010, 3'd4, 32'h0, "R6 arbitration");

    // R7 R9 R12 entry 5 halves
    sel(8'h1A);
    wr(12'h010, 3'd4, 32'h0000_A030);
    check("R9 strobe low-half write", {63'b0, strobe_seen}, 1);
    @(negedge clk);
    check("R9 strobe one cycle", {63'b0, entry_changed}, 0);
    rd(12'h010, 3'd4, 32'h0000_A030, "R7 entry5 low");
    sel(8'h1B);
    wr(12'h010, 3'd4, 32'hC300_0000);
    check("R9 strobe high-half write", {63'b0, strobe_seen}, 1);
    rd(12'h010, 3'd4, 32'hC300_0000, "R7 entry5 high");
    sel(8'h1A);
    rd(12'h010, 3'd4, 32'h0000_A030, "R7 low half kept");
    check("R12 table entry5", table_o[5*64 +: 64], 64'hC300_0000_0000_A030);

    // R10 status bits
    wr(12'h010, 3'd4, 32'h0001_5055);
    check("R12 status not exported", table_o[5*64 +: 64], 64'hC300_0000_0001_0055);
    rd(12'h010, 3'd4, 32'h0001_0055, "R10 status write dropped");
    remote_irr_i[5] = 1;
    rd(12'h010, 3'd4, 32'h0001_4055, "R10 live remote irr");
    deliv_stat_i[5] = 1;
    rd(12'h010, 3'd4, 32'h0001_5055, "R10 live delivery status");
    remote_irr_i = 0; deliv_stat_i = 0;

    // R3 narrow window access
    wr(12'h010, 3'd2, 32'h0000_FFFF);
    check("R3 no strobe narrow", {63'b0, strobe_seen}, 0);
    rd(12'h010, 3'd4, 32'h0001_0055, "R3 narrow write ignored");
    rd(12'h010, 3'd2, 32'h0, "R3 narrow read zero");

    // R8 out-of-range selectors
    sel(8'h05);
    wr(12'h010, 3'd4, 32'hFFFF_FFFF);
    check("R8 no strobe gap", {63'b0, strobe_seen}, 0);
    rd(12'h010, 3'd4, 32'h0, "R8 gap reads zero");
    sel(8'h40);
    wr(12'h010, 3'd4, 32'hFFFF_FFFF);
    check("R8 no strobe past table", {63'b0, strobe_seen}, 0);
    rd(12'h010, 3'd4, 32'h0, "R8 past table zero");
    check("R8 entry0 untouched", table_o[0 +: 64], 64'h0000_0000_0001_0000);
    check("R8 entry23 untouched", table_o[23*64 +: 64], 64'h0000_0000_0001_0000);

    // last entry
    sel(8'h3F);
    wr(12'h010, 3'd4, 32'hAB00_0000);
    rd(12'h010, 3'd4, 32'hAB00_0000, "R7 entry23 high");
    check("R12 table entry23", table_o[23*64 +: 64], 64'hAB00_0000_0001_0000);

    // R13 address decode
    rd(12'h310, 3'd4, 32'hAB00_0000, "R13 upper bits ignored");
    wr(12'h020, 3'd4, 32'h0000_0011);
    rd(12'h000, 3'd4, 32'h0000_003F, "R13 stray write no effect");
    rd(12'h020, 3'd4, 32'h0, "R13 stray offset reads zero");

    repeat (3) @(negedge clk);
    check("R11 all reads answered", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule